// File: doc/BRIEF.md
# Saturating Fixed-Point Arithmetic Unit

This block is a 32-bit two's-complement arithmetic unit for signal-processing datapaths. It treats operands as integers or as Q31 fractions. Each clock it takes two operands, an opcode, a carry input and a saturate-enable bit. It computes the selected operation in one combinational pass and captures the result and four status flags in output registers. The flags are zero, negative, overflow and carry.

With saturation off, results wrap modulo 2^32. With saturation on, a signed overflow is replaced by the nearest representable extreme. The unsigned add clamps to all ones instead. The overflow flag always reports the unclamped overflow, so software can tell that a clamp took place. A compare operation updates only the flags. Opcodes outside the defined set change nothing.

Top module: `sat_alu`

## Requirements
- R1: While rst_ni is low, res_o is 0 and zero_o, neg_o, ovf_o and carry_o are 0, and an assertion of rst_ni clears them without waiting for a clock.
- R2: op_i=0 gives a+b, 1 gives a+b+carry_i, 2 gives a-b, 3 gives a-b+carry_i-1. With sat_en_i low these wrap modulo 2^32. The result and flags appear one rising clk_i edge after the inputs.
- R3: With sat_en_i high, a signed overflow in opcodes 0,1,2,3,5,6,7,8 yields 0x7FFFFFFF when the true result is too large and 0x80000000 when it is too small.
- R4: ovf_o is the signed overflow of the unclamped result, set whether or not the output was clamped. An add of operands with differing signs never sets it. A subtract of operands with equal signs never sets it.
- R5: op_i=5 (negate) and op_i=6 (absolute value) applied to 0x80000000 return 0x80000000 with ovf_o=1 when sat_en_i is low, and 0x7FFFFFFF with ovf_o=1 when it is high.
- R6: op_i=5 gives -a, 6 gives |a|, 7 gives a+1, 8 gives a-1. Each has the same overflow and saturation behaviour as R3/R4.
- R7: op_i=4 gives floor((a+b)/2) of the signed operands, computed with a 33-bit sum. It never overflows: ovf_o=0, and carry_o is the carry out of bit 31 of a+b.
- R8: op_i=9 returns the signed minimum of a and b, and op_i=10 the signed maximum. Both return ovf_o=0 and carry_o=0.
- R9: op_i=11 (compare) sets the flags from a-b. zero_o and neg_o are taken from the raw difference. res_o keeps its previous value.
- R10: op_i=12 is an unsigned add. ovf_o and carry_o both equal the carry out of bit 31. With sat_en_i high an overflowing sum gives 0xFFFFFFFF.
- R11: For every result-writing opcode, zero_o and neg_o describe the value written to res_o. For adds, carry_o is the carry out of bit 31. For subtracts, including compare, negate and decrement, carry_o is 1 when no borrow occurs (a + ~b + carry-in form).
- R12: op_i values 13 to 15 leave res_o and all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry input for opcodes 1 and 3 |
| sat_en_i | input | 1 | Saturation enable |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |
| ovf_o | output | 1 | Registered overflow flag (raw) |
| carry_o | output | 1 | Registered carry flag |

## Verification
The only state in the block is the result register and the flag register. A fault in either shows at the ports one edge after the operation that wrote it. A wrongly updated register shows up at once on a compare or on a reserved opcode, where both outputs must hold. Operand routing and clamp faults show up as a wrong extreme on overflow vectors. Examples are a swapped clamp direction, a clamp applied to the wrong opcode, or an overflow flag taken after clamping. The bench exercises these through overflow of both signs, the most-negative operand under negate, absolute value and decrement, and the unsigned wrap.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AVG  = 4'd4,
    OP_NEG  = 4'd5,
    OP_ABS  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_MIN  = 4'd9,
    OP_MAX  = 4'd10,
    OP_CMP  = 4'd11,
    OP_ADDU = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/sat_alu_opsel.sv
// Maps every opcode onto one x + y + cin adder form.
module sat_alu_opsel
  import sat_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            carry_i,
  output logic [W-1:0]    x_o,
  output logic [W-1:0]    y_o,
  output logic            cin_o
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;

  always_comb begin
    x_o   = a_i;
    y_o   = b_i;
    cin_o = 1'b0;
    case (op_i)
      OP_ADDC: cin_o = carry_i;
      OP_SUB, OP_MIN, OP_MAX, OP_CMP: begin
        y_o   = ~b_i;
        cin_o = 1'b1;
      end
      OP_SUBC: begin
        y_o   = ~b_i;
        cin_o = carry_i;
      end
      OP_NEG: begin
        x_o   = ZERO;
        y_o   = ~a_i;
        cin_o = 1'b1;
      end
      OP_ABS: begin
        if (a_i[W-1]) begin
          x_o   = ZERO;
          y_o   = ~a_i;
          cin_o = 1'b1;
        end else begin
          y_o   = ZERO;
        end
      end
      OP_INC: begin
        y_o   = ZERO;
        cin_o = 1'b1;
      end
      OP_DEC: y_o = ONES;
      default: ;
    endcase
  end

endmodule

// File: rtl/sat_alu_adder.sv
module sat_alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         sovf_o,
  output logic         ovf_neg_o
);

  logic [W:0] u_ext;
  logic [W:0] s_ext;

  assign u_ext = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  // sign-extended copy: bit W vs bit W-1 exposes signed overflow and its direction
  assign s_ext = {x_i[W-1], x_i} + {y_i[W-1], y_i} + {{W{1'b0}}, cin_i};

  assign sum_o     = u_ext[W-1:0];
  assign cout_o    = u_ext[W];
  assign sovf_o    = s_ext[W] ^ s_ext[W-1];
  assign ovf_neg_o = s_ext[W];

endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] raw_i,
  input  logic         sovf_i,
  input  logic         ovf_neg_i,
  input  logic         uovf_i,
  input  logic         uns_i,
  input  logic         en_i,
  output logic [W-1:0] res_o
);

  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] U_MAX = '1;

  always_comb begin
    res_o = raw_i;
    if (en_i) begin
      if (uns_i) begin
        if (uovf_i) res_o = U_MAX;
      end else if (sovf_i) begin
        res_o = ovf_neg_i ? S_MIN : S_MAX;
      end
    end
  end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            carry_i,
  input  logic            sat_en_i,
  output logic [W-1:0]    res_o,
  output logic            zero_o,
  output logic            neg_o,
  output logic            ovf_o,
  output logic            carry_o
);

  logic [W-1:0] x, y, sum, sat_res, nxt_res, res_q;
  logic         cin, cout, sovf, ovf_neg;
  logic [W:0]   avg_sum;
  logic         a_lt_b, arith_op, uns_op, wr_res, wr_flg;
  alu_flags_t   nxt_flg, flg_q;

  sat_alu_opsel #(.W(W)) u_opsel (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .x_o     (x),
    .y_o     (y),
    .cin_o   (cin)
  );

  sat_alu_adder #(.W(W)) u_adder (
    .x_i       (x),
    .y_i       (y),
    .cin_i     (cin),
    .sum_o     (sum),
    .cout_o    (cout),
    .sovf_o    (sovf),
    .ovf_neg_o (ovf_neg)
  );

  assign arith_op = op_i inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG,
                                 OP_ABS, OP_INC, OP_DEC, OP_ADDU};
  assign uns_op   = (op_i == OP_ADDU);

  sat_alu_clamp #(.W(W)) u_clamp (
    .raw_i     (sum),
    .sovf_i    (sovf),
    .ovf_neg_i (ovf_neg),
    .uovf_i    (cout),
    .uns_i     (uns_op),
    .en_i      (sat_en_i & arith_op),
    .res_o     (sat_res)
  );

  // 33-bit signed sum; dropping the LSB is an arithmetic halving with floor
  assign avg_sum = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  // signed a < b from the a - b adder pass
  assign a_lt_b  = sum[W-1] ^ sovf;

  always_comb begin
    nxt_res = res_q;
    nxt_flg = flg_q;
    wr_res  = 1'b0;
    wr_flg  = 1'b0;
    if (arith_op) begin
      nxt_res   = sat_res;
      nxt_flg.v = uns_op ? cout : sovf;
      nxt_flg.c = cout;
      wr_res    = 1'b1;
      wr_flg    = 1'b1;
    end else begin
      case (op_i)
        OP_AVG: begin
          nxt_res   = avg_sum[W:1];
          nxt_flg.v = 1'b0;
          nxt_flg.c = cout;
          wr_res    = 1'b1;
          wr_flg    = 1'b1;
        end
        OP_MIN, OP_MAX: begin
          nxt_res   = (a_lt_b ^ (op_i == OP_MAX)) ? a_i : b_i;
          nxt_flg.v = 1'b0;
          nxt_flg.c = 1'b0;
          wr_res    = 1'b1;
          wr_flg    = 1'b1;
        end
        OP_CMP: begin
          nxt_flg.v = sovf;
          nxt_flg.c = cout;
          wr_flg    = 1'b1;
        end
        default: ;
      endcase
    end
    if (op_i == OP_CMP) begin
      nxt_flg.z = (sum == '0);
      nxt_flg.n = sum[W-1];
    end else begin
      nxt_flg.z = (nxt_res == '0);
      nxt_flg.n = nxt_res[W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      if (wr_res) res_q <= nxt_res;
      if (wr_flg) flg_q <= nxt_flg;
    end
  end

  assign res_o   = res_q;
  assign zero_o  = flg_q.z;
  assign neg_o   = flg_q.n;
  assign ovf_o   = flg_q.v;
  assign carry_o = flg_q.c;

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
  import sat_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic            carry_i,
  input logic            sat_en_i,
  input logic [W-1:0]    res_o,
  input logic            zero_o,
  input logic            neg_o,
  input logic            ovf_o,
  input logic            carry_o
);

  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] U_MAX = '1;

  logic [W-1:0] add_s;
  logic [W:0]   addu_s;
  logic         add_ovf;
  logic         unused_carry;

  assign add_s        = a_i + b_i;
  assign addu_s       = {1'b0, a_i} + {1'b0, b_i};
  assign add_ovf      = (a_i[W-1] == b_i[W-1]) && (add_s[W-1] != a_i[W-1]);
  assign unused_carry = carry_i;

  AST_SAT_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && sat_en_i && add_ovf && !a_i[W-1]) |=> (res_o == S_MAX)); // R3
  AST_SAT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && sat_en_i && add_ovf && a_i[W-1]) |=> (res_o == S_MIN)); // R3
  AST_MIXED_SIGN_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && a_i[W-1] != b_i[W-1]) |=> !ovf_o); // R4
  AST_RAW_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && add_ovf) |=> ovf_o); // R4
  AST_NEG_MIN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NEG && sat_en_i && a_i == S_MIN) |=> (res_o == S_MAX && ovf_o)); // R5
  AST_NEG_MIN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NEG && !sat_en_i && a_i == S_MIN) |=> (res_o == S_MIN && ovf_o)); // R5
  AST_AVG_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_AVG) |=> !ovf_o); // R7
  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |=> $stable(res_o)); // R9
  AST_ADDU_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADDU && sat_en_i && addu_s[W]) |=> (res_o == U_MAX && ovf_o)); // R10
  AST_RSV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_ADDU) |=> ($stable(res_o) && $stable({zero_o, neg_o, ovf_o, carry_o}))); // R12

endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .carry_i  (carry_i),
  .sat_en_i (sat_en_i),
  .res_o    (res_o),
  .zero_o   (zero_o),
  .neg_o    (neg_o),
  .ovf_o    (ovf_o),
  .carry_o  (carry_o)
);

// File: tb/sat_alu_tb_top.sv
module sat_alu_tb_top;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic        ci;
    logic        sat;
    logic [31:0] res;
    logic [3:0]  flg;  // {z,n,v,c}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h00000000, 4'b1001, 4'd11}, // R11 -1+1
    '{4'd0,  32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h80000000, 4'b0110, 4'd2},  // R2 wrap
    '{4'd0,  32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b1, 32'h7FFFFFFF, 4'b0010, 4'd3},  // R3
    '{4'd0,  32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b1, 32'h80000000, 4'b0111, 4'd3},  // R3
    '{4'd2,  32'h80000000, 32'h00000001, 1'b0, 1'b0, 32'h7FFFFFFF, 4'b0011, 4'd4},  // R4
    '{4'd2,  32'h80000000, 32'h00000001, 1'b0, 1'b1, 32'h80000000, 4'b0111, 4'd3},  // R3
    '{4'd2,  32'h00000005, 32'h00000007, 1'b0, 1'b1, 32'hFFFFFFFE, 4'b0100, 4'd11}, // R11 borrow
    '{4'd1,  32'h0000000A, 32'h00000014, 1'b1, 1'b0, 32'h0000001F, 4'b0000, 4'd2},  // R2
    '{4'd3,  32'h0000000A, 32'h00000003, 1'b0, 1'b0, 32'h00000006, 4'b0001, 4'd2},  // R2
    '{4'd3,  32'h0000000A, 32'h00000003, 1'b1, 1'b0, 32'h00000007, 4'b0001, 4'd2},  // R2
    '{4'd1,  32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b1, 32'h7FFFFFFF, 4'b0010, 4'd3},  // R3
    '{4'd5,  32'h80000000, 32'h00000000, 1'b0, 1'b0, 32'h80000000, 4'b0110, 4'd5},  // R5
    '{4'd5,  32'h80000000, 32'h00000000, 1'b0, 1'b1, 32'h7FFFFFFF, 4'b0010, 4'd5},  // R5
    '{4'd5,  32'h00000005, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFB, 4'b0100, 4'd6},  // R6
    '{4'd5,  32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 4'b1001, 4'd6},  // R6
    '{4'd6,  32'hFFFFFFF9, 32'h00000000, 1'b0, 1'b0, 32'h00000007, 4'b0000, 4'd6},  // R6
    '{4'd6,  32'h0000000C, 32'h00000000, 1'b0, 1'b0, 32'h0000000C, 4'b0000, 4'd6},  // R6
    '{4'd6,  32'h80000000, 32'h00000000, 1'b0, 1'b1, 32'h7FFFFFFF, 4'b0010, 4'd5},  // R5
    '{4'd7,  32'h7FFFFFFF, 32'h00000000, 1'b0, 1'b1, 32'h7FFFFFFF, 4'b0010, 4'd6},  // R6
    '{4'd8,  32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFF, 4'b0100, 4'd6},  // R6
    '{4'd8,  32'h80000000, 32'h00000000, 1'b0, 1'b1, 32'h80000000, 4'b0111, 4'd6},  // R6
    '{4'd4,  32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1, 32'h7FFFFFFF, 4'b0000, 4'd7},  // R7
    '{4'd4,  32'hFFFFFFFD, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFE, 4'b0100, 4'd7},  // R7 floor
    '{4'd4,  32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h00000000, 4'b1001, 4'd7},  // R7
    '{4'd9,  32'h80000000, 32'h7FFFFFFF, 1'b0, 1'b0, 32'h80000000, 4'b0100, 4'd8},  // R8
    '{4'd10, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'h00000001, 4'b0000, 4'd8},  // R8
    '{4'd9,  32'h00000004, 32'h00000004, 1'b0, 1'b0, 32'h00000004, 4'b0000, 4'd8},  // R8
    '{4'd11, 32'h00000003, 32'h00000003, 1'b0, 1'b0, 32'h00000004, 4'b1001, 4'd9},  // R9
    '{4'd11, 32'h80000000, 32'h00000001, 1'b0, 1'b0, 32'h00000004, 4'b0011, 4'd9},  // R9
    '{4'd12, 32'hFFFFFFFF, 32'h00000002, 1'b0, 1'b1, 32'hFFFFFFFF, 4'b0111, 4'd10}, // R10
    '{4'd13, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 32'hFFFFFFFF, 4'b0111, 4'd12}, // R12
    '{4'd12, 32'hFFFFFFFF, 32'h00000002, 1'b0, 1'b0, 32'h00000001, 4'b0011, 4'd10}, // R10
    '{4'd12, 32'h00000001, 32'h00000002, 1'b0, 1'b1, 32'h00000003, 4'b0000, 4'd10}, // R10
    '{4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 32'h00000003, 4'b0000, 4'd12}, // R12
    '{4'd2,  32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 32'h7FFFFFFF, 4'b0010, 4'd3}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        carry_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic [31:0] res_o;
  logic        zero_o, neg_o, ovf_o, carry_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sat_alu dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .carry_i  (carry_i),
    .sat_en_i (sat_en_i),
    .res_o    (res_o),
    .zero_o   (zero_o),
    .neg_o    (neg_o),
    .ovf_o    (ovf_o),
    .carry_o  (carry_o)
  );

  task automatic check(input string req, input logic [31:0] exp_res, input logic [3:0] exp_flg);
    n_chk++;
    if (res_o !== exp_res || {zero_o, neg_o, ovf_o, carry_o} !== exp_flg) begin
      n_bad++;
      $display("FAIL %s: res=%h flags=%b expected res=%h flags=%b", req, res_o,
               {zero_o, neg_o, ovf_o, carry_o}, exp_res, exp_flg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    op_i = 4'd0; a_i = 32'h7FFFFFFF; b_i = 32'h1;
    @(negedge clk);
    check("R1 in reset", 32'h0, 4'b0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op_i = VECS[i].op; a_i = VECS[i].a; b_i = VECS[i].b;
      carry_i = VECS[i].ci; sat_en_i = VECS[i].sat;
      @(negedge clk);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].res, VECS[i].flg);
    end

    // R1: asynchronous clear between edges
    op_i = 4'd13;
    #3 rst_ni = 1'b0;
    #1 check("R1 async clear", 32'h0, 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
    op_i = 4'd0; a_i = 32'h00000002; b_i = 32'h00000003; sat_en_i = 1'b0;
    @(negedge clk);
    check("R2 after reset", 32'h00000005, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule